// File: doc/BRIEF.md
# Serial Channel Interrupt Request Logic

This block sits beside a byte-oriented asynchronous serial channel and turns the channel's event strobes into status flags and four separate interrupt request lines. The four lines are receive error, receive data full, transmit data empty and transmission end. Each flag is set by a single-cycle strobe from the channel. Software can clear a flag by writing zero to it, but only after it has read that flag as one. A separate transfer controller serves the two data requests. When it completes a move, it clears the matching data flag by itself.

Each request line has its own enable bit. A request is a level that comes from a registered flag and its enable bit, with no register in between. Only the receive-full and transmit-empty requests go out as transfer triggers. A fixed-priority picker reports which pending request should be served first. In that order, transmit-empty always comes before transmission-end. The number of error flags is a parameter. A second parameter removes the transfer-controller path entirely.

Top module: `serial_irq_logic`

## Requirements
- R1: After reset the status vector `stat_o` reads 6'b110000: transmit-empty (bit 5) and transmission-end (bit 4) are 1, all other flags are 0, all enable bits are 0, and no request, trigger or `irq_any` is active.
- R2: Each channel strobe sets its own flag at the next clock edge. The flag positions are: error flags at bits 0 (overrun), 1 (framing) and 2 (parity), receive-full at bit 3, transmission-end at bit 4, transmit-empty at bit 5.
- R3: `irq_txempty` is high exactly while flag bit 5 and enable bit 2 are both 1, and `xfer_req_tx` follows it.
- R4: `irq_txend` is high exactly while flag bit 4 and enable bit 3 are both 1. It never raises a transfer trigger.
- R5: `irq_rxfull` is high exactly while flag bit 3 and enable bit 1 are both 1, and `xfer_req_rx` follows it. With the enable bit at 0, a set flag raises neither output.
- R6: `irq_rxerr` is high while any error flag is 1 and enable bit 0 is 1. It never raises a transfer trigger.
- R7: A transfer-complete strobe clears only its own data flag: `xfer_done_tx` clears bit 5 and `xfer_done_rx` clears bit 3.
- R8: A status write clears each bit written as 0, provided that flag was read as 1 by a status read since the last write. A write of 0 without such a read, or a write of 1, leaves the flag unchanged.
- R9: A flag that is set by its strobe in the same cycle as a software clear stays set.
- R10: `irq_pick` gives the code of the pending request to serve first, the lowest code winning: 0 error, 1 receive-full, 2 transmit-empty, 3 transmission-end. So transmit-empty is picked before transmission-end. `irq_any` shows that a request is pending.
- R11: If one status write clears transmit-empty and transmission-end together, no transmission-end request follows in later cycles.
- R12: A request drops in the cycle after its flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_stb | input | ERR_W | Error strobes (overrun, framing, parity) |
| rx_done_stb | input | 1 | Byte received |
| tx_load_stb | input | 1 | Transmit buffer moved to shifter |
| tx_idle_stb | input | 1 | Last stop bit sent |
| xfer_done_rx | input | 1 | Transfer controller read the received byte |
| xfer_done_tx | input | 1 | Transfer controller wrote the transmit byte |
| ctl_wr | input | 1 | Enable register write strobe |
| ctl_wdata | input | 4 | Enables: bit0 error, bit1 rx full, bit2 tx empty, bit3 tx end |
| sw_rd | input | 1 | Status read strobe |
| sw_wr | input | 1 | Status write strobe |
| sw_wdata | input | ERR_W+3 | Status write data (0 clears) |
| stat_o | output | ERR_W+3 | Status flags |
| irq_rxerr | output | 1 | Receive error request |
| irq_rxfull | output | 1 | Receive data full request |
| irq_txempty | output | 1 | Transmit data empty request |
| irq_txend | output | 1 | Transmission end request |
| xfer_req_rx | output | 1 | Transfer trigger, receive |
| xfer_req_tx | output | 1 | Transfer trigger, transmit |
| irq_pick | output | 2 | Code of request to serve first |
| irq_any | output | 1 | Any request pending |

## Verification
Several rules are checked by assertions on every cycle. A strobe always sets its flag. A write of 0 with no prior read never changes a flag. A transfer trigger is never active without its data flag. A completed transfer clears its flag. The picked code always names a pending request, with transmit-empty winning over transmission-end. Other behaviour needs a sequence of steps that only the bench scenarios can show. These cover the read-then-write clear, a strobe colliding with a clear, the absence of a later transmission-end request after both transmit flags clear together, and the effect of each enable bit.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;
   localparam int NUM_SRC = 4;
   localparam int SRC_W   = 2;

   // request codes, lower code served first
   typedef enum logic [SRC_W-1:0] {
      SRC_ERR  = 2'd0,
      SRC_RXF  = 2'd1,
      SRC_TXE  = 2'd2,
      SRC_TEND = 2'd3
   } src_e;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic hw_clr_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic q_o
);
   logic armed_q;
   logic sw_clr;

   assign sw_clr = wr_i & ~wbit_i & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o     <= RST_VAL;
         armed_q <= 1'b0;
      end else begin
         if (set_i)
            q_o <= 1'b1;
         else if (sw_clr || hw_clr_i)
            q_o <= 1'b0;
         armed_q <= wr_i ? 1'b0 : (q_o & (armed_q | rd_i));
      end
   end

   // R2 R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);

   // R8
   unread_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wbit_i && !armed_q && !set_i && !hw_clr_i) |=> $stable(q_o));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
   parameter int N = 4,
   localparam int PW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   output logic [PW-1:0] pick_o,
   output logic          any_o
);
   if (N < 2) begin : g_bad_n
      $error("irq_prio needs at least two sources");
   end

   always_comb begin
      pick_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) pick_o = PW'(i);
      end
   end
   assign any_o = |req_i;

   // R10
   pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> req_i[pick_o]);

   // R10
   pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[0] |-> pick_o == '0));
endmodule

// File: rtl/serial_irq_logic.sv
module serial_irq_logic
   import serial_irq_pkg::*;
#(
   parameter int ERR_W   = 3,
   parameter bit XFER_EN = 1'b1,
   localparam int FLAG_W = ERR_W + 3,
   localparam int B_RXF  = ERR_W,
   localparam int B_TEND = ERR_W + 1,
   localparam int B_TXE  = ERR_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ERR_W-1:0]  err_stb,
   input  logic              rx_done_stb,
   input  logic              tx_load_stb,
   input  logic              tx_idle_stb,
   input  logic              xfer_done_rx,
   input  logic              xfer_done_tx,
   input  logic              ctl_wr,
   input  logic [NUM_SRC-1:0] ctl_wdata,
   input  logic              sw_rd,
   input  logic              sw_wr,
   input  logic [FLAG_W-1:0] sw_wdata,
   output logic [FLAG_W-1:0] stat_o,
   output logic              irq_rxerr,
   output logic              irq_rxfull,
   output logic              irq_txempty,
   output logic              irq_txend,
   output logic              xfer_req_rx,
   output logic              xfer_req_tx,
   output logic [SRC_W-1:0]  irq_pick,
   output logic              irq_any
);
   if (ERR_W < 1 || ERR_W > 8) begin : g_bad_err_w
      $error("ERR_W must be 1..8");
   end

   localparam logic [FLAG_W-1:0] RST_VEC = {2'b11, {(ERR_W + 1){1'b0}}};

   logic [NUM_SRC-1:0] en_q;
   logic [FLAG_W-1:0]  set_vec;
   logic [FLAG_W-1:0]  hclr_vec;
   logic [NUM_SRC-1:0] req_vec;
   logic               hclr_rx, hclr_tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (ctl_wr) en_q <= ctl_wdata;
   end

   // transfer controller path, present or removed
   if (XFER_EN) begin : g_xfer
      assign hclr_rx     = xfer_done_rx;
      assign hclr_tx     = xfer_done_tx;
      assign xfer_req_rx = irq_rxfull;
      assign xfer_req_tx = irq_txempty;
   end else begin : g_no_xfer
      logic unused_done;
      assign unused_done = xfer_done_rx ^ xfer_done_tx;
      assign hclr_rx     = 1'b0;
      assign hclr_tx     = 1'b0;
      assign xfer_req_rx = 1'b0;
      assign xfer_req_tx = 1'b0;
   end

   assign set_vec  = {tx_load_stb, tx_idle_stb, rx_done_stb, err_stb};
   assign hclr_vec = {hclr_tx, 1'b0, hclr_rx, {ERR_W{1'b0}}};

   for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      irq_flag_cell #(.RST_VAL(RST_VEC[i])) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (set_vec[i]),
         .hw_clr_i (hclr_vec[i]),
         .rd_i     (sw_rd),
         .wr_i     (sw_wr),
         .wbit_i   (sw_wdata[i]),
         .q_o      (stat_o[i])
      );
   end

   assign irq_rxerr   = en_q[SRC_ERR]  & (|stat_o[ERR_W-1:0]);
   assign irq_rxfull  = en_q[SRC_RXF]  & stat_o[B_RXF];
   assign irq_txempty = en_q[SRC_TXE]  & stat_o[B_TXE];
   assign irq_txend   = en_q[SRC_TEND] & stat_o[B_TEND];

   assign req_vec = {irq_txend, irq_txempty, irq_rxfull, irq_rxerr};

   irq_prio #(.N(NUM_SRC)) u_prio (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_vec),
      .pick_o (irq_pick),
      .any_o  (irq_any)
   );

   // R3
   tx_trig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_tx |-> stat_o[B_TXE]);

   // R5
   rx_trig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_rx |-> stat_o[B_RXF]);

   // R7
   tx_done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (XFER_EN && xfer_done_tx && !tx_load_stb) |=> !stat_o[B_TXE]);

   // R10
   txe_over_tend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_txempty && irq_txend && !irq_rxerr && !irq_rxfull) |-> irq_pick == SRC_TXE);
endmodule

// File: tb/serial_irq_logic_test.sv
module serial_irq_logic_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] err_stb = '0;
   logic       rx_done_stb = 0, tx_load_stb = 0, tx_idle_stb = 0;
   logic       xfer_done_rx = 0, xfer_done_tx = 0;
   logic       ctl_wr = 0;
   logic [3:0] ctl_wdata = '0;
   logic       sw_rd = 0, sw_wr = 0;
   logic [5:0] sw_wdata = '0;
   logic [5:0] stat_o;
   logic       irq_rxerr, irq_rxfull, irq_txempty, irq_txend;
   logic       xfer_req_rx, xfer_req_tx, irq_any;
   logic [1:0] irq_pick;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   serial_irq_logic uut (
      .clk(clk), .rst_n(rst_n), .err_stb(err_stb), .rx_done_stb(rx_done_stb),
      .tx_load_stb(tx_load_stb), .tx_idle_stb(tx_idle_stb),
      .xfer_done_rx(xfer_done_rx), .xfer_done_tx(xfer_done_tx),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sw_rd(sw_rd), .sw_wr(sw_wr),
      .sw_wdata(sw_wdata), .stat_o(stat_o), .irq_rxerr(irq_rxerr),
      .irq_rxfull(irq_rxfull), .irq_txempty(irq_txempty), .irq_txend(irq_txend),
      .xfer_req_rx(xfer_req_rx), .xfer_req_tx(xfer_req_tx),
      .irq_pick(irq_pick), .irq_any(irq_any)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic ctl_write(input logic [3:0] d);
      ctl_wr = 1; ctl_wdata = d; step(); ctl_wr = 0;
   endtask

   task automatic sw_read();
      sw_rd = 1; step(); sw_rd = 0;
   endtask

   task automatic sw_write(input logic [5:0] d);
      sw_wr = 1; sw_wdata = d; step(); sw_wr = 0;
   endtask

   task automatic t_reset();
      chk("R1 stat", stat_o, 6'b110000);
      chk("R1 irqs", {irq_rxerr, irq_rxfull, irq_txempty, irq_txend}, 0);
      chk("R1 trig", {xfer_req_rx, xfer_req_tx, irq_any}, 0);
   endtask

   task automatic t_tx_pair();
      ctl_write(4'b1100);
      chk("R3 txe", irq_txempty, 1);
      chk("R4 tend", irq_txend, 1);
      chk("R3 trig", {xfer_req_tx, xfer_req_rx}, 2'b10);
      chk("R10 txe first", irq_pick, 2);
      xfer_done_tx = 1; step(); xfer_done_tx = 0;
      chk("R7 tx clear", stat_o, 6'b010000);
      chk("R12 txe drop", irq_txempty, 0);
      chk("R4 no trig", {xfer_req_tx, xfer_req_rx}, 0);
      chk("R10 tend next", irq_pick, 3);
   endtask

   task automatic t_sw_clear();
      sw_write(6'b000000);
      chk("R8 unread", stat_o[4], 1);
      sw_read();
      sw_write(6'b111111);
      chk("R8 write one", stat_o[4], 1);
      sw_read();
      sw_write(6'b000000);
      chk("R8 clear", stat_o[4], 0);
      chk("R12 tend drop", {irq_txend, irq_any}, 0);
   endtask

   task automatic t_both_clear();
      tx_load_stb = 1; tx_idle_stb = 1; step(); tx_load_stb = 0; tx_idle_stb = 0;
      chk("R2 tx bits", stat_o, 6'b110000);
      sw_read();
      sw_write(6'b000000);
      chk("R11 both clear", stat_o, 0);
      for (int i = 0; i < 4; i++) begin
         step();
         chk("R11 no tend", {irq_txend, irq_any}, 0);
      end
   endtask

   task automatic t_rx();
      ctl_write(4'b0010);
      rx_done_stb = 1; step(); rx_done_stb = 0;
      chk("R2 rx bit", stat_o, 6'b001000);
      chk("R5 rxf", {irq_rxfull, xfer_req_rx}, 2'b11);
      chk("R10 rxf code", irq_pick, 1);
      xfer_done_rx = 1; step(); xfer_done_rx = 0;
      chk("R7 rx clear", stat_o, 0);
      chk("R12 rxf drop", {irq_rxfull, xfer_req_rx}, 0);
   endtask

   task automatic t_collide();
      rx_done_stb = 1; step(); rx_done_stb = 0;
      sw_read();
      sw_wr = 1; sw_wdata = 0; rx_done_stb = 1; step(); sw_wr = 0; rx_done_stb = 0;
      chk("R9 set wins", stat_o[3], 1);
      sw_read();
      sw_write(6'b000000);
      chk("R8 rx clear", stat_o[3], 0);
   endtask

   task automatic t_err();
      ctl_write(4'b0011);
      for (int i = 0; i < 3; i++) begin
         err_stb = 3'(1 << i); step(); err_stb = 0;
         chk("R2 err bit", stat_o, 6'(1 << i));
         chk("R6 err irq", irq_rxerr, 1);
         chk("R6 no trig", {xfer_req_rx, xfer_req_tx}, 0);
         chk("R10 err code", irq_pick, 0);
         sw_read();
         sw_write(6'b000000);
         chk("R12 err drop", {irq_rxerr, stat_o}, 0);
      end
      err_stb = 3'b001; rx_done_stb = 1; step(); err_stb = 0; rx_done_stb = 0;
      chk("R10 err over rxf", irq_pick, 0);
      chk("R5 trig", xfer_req_rx, 1);
      sw_read();
      sw_write(6'b000000);
      chk("R8 multi clear", stat_o, 0);
   endtask

   task automatic t_disabled();
      ctl_write(4'b0000);
      rx_done_stb = 1; err_stb = 3'b100; step(); rx_done_stb = 0; err_stb = 0;
      chk("R5 disabled flag", stat_o, 6'b001100);
      chk("R5 disabled irq", {irq_rxfull, xfer_req_rx, irq_rxerr, irq_any}, 0);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset();
      t_tx_pair();
      t_sw_clear();
      t_both_clear();
      t_rx();
      t_collide();
      t_err();
      t_disabled();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule